// File: doc/BRIEF.md
# SDRAM Command Bus Protocol Monitor

This block watches the command pins of a single-data-rate SDRAM each rising clock edge without driving anything. It decodes the command, keeps a state for every bank (idle, open, or running a burst that ends in auto-precharge), and holds the burst length, burst ordering and read latency last programmed into the mode register. Orderings the memory cannot accept raise bits in a sticky error vector, one bit per kind of violation, and an 8-bit counter tallies the clock cycles on which any violation appeared.

It also predicts the data bus. It shows which clock periods carry read data, given the read latency and burst length, and which read beats the byte masks will tri-state. It shows which write beats the byte masks blocked. It can sit beside a memory controller in a simulation bench, or be built into silicon as a debug observer.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: A command is decoded only when `cs_n` is low and `cke` was high at the previous edge. The pins `{cs_n,ras_n,cas_n,we_n}` are decoded as follows: 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 refresh (auto or self), 0000 mode-register load, 0110 burst stop and 0111 no-op. Anything else is ignored and leaves all state unchanged.
- R2: A mode-register load or a refresh while any bank is not idle sets `err_vec[0]`.
- R3: Any decoded command other than no-op on either of the 2 edges after a mode-register load sets `err_vec[1]`.
- R4: A read or write to an idle bank sets `err_vec[2]`. An activate to a bank that is not idle sets `err_vec[3]` and leaves that bank's state unchanged.
- R5: A read or write to a bank that is running an auto-precharge burst sets `err_vec[4]`. A read or write issued with `ap` high makes its bank busy for the burst. The bank turns idle on the last beat, or when a burst stop or another read or write cuts the burst short. With a burst length of 1 it turns idle at once.
- R6: A mode-register load latches `mode_key[2:0]` as the burst-length code, `mode_key[3]` as the interleave flag and `mode_key[6:4]` as the read latency. After reset these read 0, 0 and 3.
- R7: Burst-length codes 0, 1, 2, 3 and 7 give 1, 2, 4, 8 and 256 (full page) beats; the other codes give 1. For a read at edge t with latency CL, `rd_slot` is high in the clock periods ending at edges t+CL through t+CL+BL-1. A latency code of 0 or above 3 is treated as 3.
- R8: A burst stop ends the current burst. It carries no beat.
- R9: A read beat is tri-stated two edges after `dqm` is sampled. `rd_hiz` equals the `dqm` value from two edges earlier whenever `rd_slot` is high, and is 0 otherwise.
- R10: Write masking applies at the same edge. After each edge that carries a write beat, `wr_mask` shows the `dqm` sampled at that edge. After any other edge it shows 0.
- R11: Error bits stay set until `clr` is high at an edge. A violation detected at that same edge is still recorded.
- R12: `err_cnt` counts edges that carry at least one violation, saturates at 255, and is zeroed by `clr`.
- R13: A precharge with `ap` high closes every bank. With `ap` low it closes only the bank on `ba`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Clears the error vector and the counter |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ap | input | 1 | Auto-precharge / all-banks address bit |
| mode_key | input | 7 | Low address bits carrying the mode key |
| ba | input | 2 | Bank address |
| dqm | input | 8 | Byte masks |
| err_vec | output | 5 | Sticky violation bits |
| err_cnt | output | 8 | Saturating count of violation edges |
| bank_open | output | 4 | One bit per bank, high when the bank is not idle |
| cas_lat | output | 3 | Latched read-latency field |
| burst_code | output | 3 | Latched burst-length field |
| burst_ilv | output | 1 | Latched interleave flag |
| rd_slot | output | 1 | Read data expected on the bus this period |
| rd_hiz | output | 8 | Bytes predicted tri-state in this read period |
| wr_mask | output | 8 | Bytes blocked on the previous write beat |

## Verification
The assertions assume that every command pin, the bank address, the mode key and the byte masks hold known values at each edge after reset. They also assume that only one burst is in flight at a time, which the single shared burst tracker guarantees, so at most one bank can be in the auto-precharge state. The stimulus drives every input from the falling edge with defined values. It never leaves a pin unknown, and it changes the mode register only after precharging all banks, except where a violation is provoked on purpose.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;
   typedef enum logic [2:0] {
      C_NOP, C_ACT, C_RD, C_WR, C_PRE, C_REF, C_MRS, C_BST
   } cmd_e;

   typedef enum logic [1:0] {
      B_IDLE, B_OPEN, B_APRE
   } bank_e;

   localparam int ERR_W     = 5;
   localparam int E_BUSY    = 0;
   localparam int E_GUARD   = 1;
   localparam int E_IDLE    = 2;
   localparam int E_ACTOPEN = 3;
   localparam int E_APBUSY  = 4;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
   import sdram_mon_pkg::*;
(
   input  logic cke_q,
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);
   always_comb begin
      cmd = C_NOP;
      if (cke_q && !cs_n) begin
         case ({ras_n, cas_n, we_n})
            3'b011:  cmd = C_ACT;
            3'b101:  cmd = C_RD;
            3'b100:  cmd = C_WR;
            3'b010:  cmd = C_PRE;
            3'b001:  cmd = C_REF;
            3'b000:  cmd = C_MRS;
            3'b110:  cmd = C_BST;
            default: cmd = C_NOP;
         endcase
      end
   end
endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
   import sdram_mon_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  cmd_e  cmd,
   input  logic  hit,
   input  logic  ap,
   input  logic  bl_one,
   input  logic  end_hit,
   output bank_e st
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= B_IDLE;
      end else begin
         case (st)
            B_IDLE:
               if (cmd == C_ACT && hit) st <= B_OPEN;
            B_OPEN:
               if (cmd == C_PRE && (hit || ap))
                  st <= B_IDLE;
               else if ((cmd == C_RD || cmd == C_WR) && hit && ap)
                  st <= bl_one ? B_IDLE : B_APRE;
            B_APRE:
               if (end_hit) st <= B_IDLE;
            default:
               st <= B_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sdram_burst_track.sv
module sdram_burst_track
   import sdram_mon_pkg::*;
#(
   parameter int BA_W   = 2,
   parameter int COL_W  = 8,
   parameter int MAX_CL = 3,
   parameter int DQM_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cmd_e             cmd,
   input  logic [BA_W-1:0]  ba,
   input  logic [DQM_W-1:0] dqm,
   input  logic [2:0]       bl_code,
   input  logic [2:0]       cl_code,
   output logic             bl_one,
   output logic             burst_end,
   output logic [BA_W-1:0]  end_bank,
   output logic             rd_slot,
   output logic [DQM_W-1:0] rd_hiz,
   output logic [DQM_W-1:0] wr_mask
);
   localparam int CNT_W = COL_W + 1;
   localparam int FULL  = 2 ** COL_W;

   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  bl_len;
   logic              is_rd;
   logic [BA_W-1:0]   cur_bank;
   logic [MAX_CL-1:0] rd_pipe;
   logic [DQM_W-1:0]  dq1, dq2;
   logic [2:0]        cl_sel;
   logic              bact, rdwr, cont, rd_now, wr_now;

   always_comb begin
      case (bl_code)
         3'd0:    bl_len = CNT_W'(1);
         3'd1:    bl_len = CNT_W'(2);
         3'd2:    bl_len = CNT_W'(4);
         3'd3:    bl_len = CNT_W'(8);
         3'd7:    bl_len = CNT_W'(FULL);
         default: bl_len = CNT_W'(1);
      endcase
   end

   assign bl_one = (bl_len == CNT_W'(1));
   assign cl_sel = (cl_code >= 3'd1 && cl_code <= 3'(MAX_CL)) ? cl_code : 3'(MAX_CL);

   assign bact   = (cnt != '0);
   assign rdwr   = (cmd == C_RD) || (cmd == C_WR);
   assign cont   = bact && (cmd != C_BST) && !rdwr;
   assign rd_now = (cmd == C_RD) || (cont && is_rd);
   assign wr_now = (cmd == C_WR) || (cont && !is_rd);

   assign burst_end = bact && ((cnt == CNT_W'(1)) || (cmd == C_BST) || rdwr);
   assign end_bank  = cur_bank;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         is_rd    <= 1'b0;
         cur_bank <= '0;
         rd_pipe  <= '0;
         dq1      <= '0;
         dq2      <= '0;
         wr_mask  <= '0;
      end else begin
         if (rdwr) begin
            cnt      <= bl_len - CNT_W'(1);
            is_rd    <= (cmd == C_RD);
            cur_bank <= ba;
         end else if (cmd == C_BST) begin
            cnt <= '0;
         end else if (bact) begin
            cnt <= cnt - CNT_W'(1);
         end
         rd_pipe <= {rd_pipe[MAX_CL-2:0], rd_now};
         dq1     <= dqm;
         dq2     <= dq1;
         wr_mask <= wr_now ? dqm : '0;
      end
   end

   always_comb begin
      rd_slot = 1'b0;
      for (int i = 0; i < MAX_CL; i++)
         if (cl_sel == 3'(i + 1)) rd_slot = rd_pipe[i];
   end

   assign rd_hiz = rd_slot ? dq2 : '0;

   // R8: a burst stop leaves no beat pending
   a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == C_BST) |=> (cnt == '0));

   // R7: a read or write always loads the beat counter below the full-page length
   a_r7_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
      rdwr |=> (cnt < CNT_W'(FULL)));
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
   import sdram_mon_pkg::*;
#(
   parameter int BA_W    = 2,
   parameter int COL_W   = 8,
   parameter int MAX_CL  = 3,
   parameter int DQM_W   = 8,
   parameter int CNT_W   = 8,
   parameter int MRS_GAP = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             cke,
   input  logic             cs_n,
   input  logic             ras_n,
   input  logic             cas_n,
   input  logic             we_n,
   input  logic             ap,
   input  logic [6:0]       mode_key,
   input  logic [BA_W-1:0]  ba,
   input  logic [DQM_W-1:0] dqm,
   output logic [ERR_W-1:0] err_vec,
   output logic [CNT_W-1:0] err_cnt,
   output logic [(2**BA_W)-1:0] bank_open,
   output logic [2:0]       cas_lat,
   output logic [2:0]       burst_code,
   output logic             burst_ilv,
   output logic             rd_slot,
   output logic [DQM_W-1:0] rd_hiz,
   output logic [DQM_W-1:0] wr_mask
);
   localparam int NBANK = 2 ** BA_W;
   localparam int GW    = $clog2(MRS_GAP + 1);
   localparam logic [CNT_W-1:0] CMAX = '1;
   localparam logic [6:0] MODE_RST = 7'b011_0_000;

   generate
      if (COL_W < 3 || COL_W > 12) begin : g_bad_col
         $error("COL_W out of range");
      end
      if (MAX_CL < 2 || MAX_CL > 7) begin : g_bad_cl
         $error("MAX_CL out of range");
      end
      if (MRS_GAP < 1) begin : g_bad_gap
         $error("MRS_GAP must be positive");
      end
   endgenerate

   logic             cke_q;
   cmd_e             cmd;
   logic [6:0]       mode_q;
   logic [GW-1:0]    guard_q;
   logic [ERR_W-1:0] err_q, new_err;
   logic [CNT_W-1:0] cnt_q;
   bank_e            bank_st [NBANK];
   logic [NBANK-1:0] apre_vec;
   logic             any_open, rdwr, bl_one, burst_end;
   logic [BA_W-1:0]  end_bank;
   bank_e            sel_st;

   sdram_cmd_decode u_dec (
      .cke_q (cke_q), .cs_n (cs_n), .ras_n (ras_n),
      .cas_n (cas_n), .we_n (we_n), .cmd (cmd)
   );

   sdram_burst_track #(
      .BA_W (BA_W), .COL_W (COL_W), .MAX_CL (MAX_CL), .DQM_W (DQM_W)
   ) u_burst (
      .clk (clk), .rst_n (rst_n), .cmd (cmd), .ba (ba), .dqm (dqm),
      .bl_code (mode_q[2:0]), .cl_code (mode_q[6:4]),
      .bl_one (bl_one), .burst_end (burst_end), .end_bank (end_bank),
      .rd_slot (rd_slot), .rd_hiz (rd_hiz), .wr_mask (wr_mask)
   );

   generate
      for (genvar b = 0; b < NBANK; b++) begin : g_bank
         sdram_bank_fsm u_fsm (
            .clk (clk), .rst_n (rst_n), .cmd (cmd),
            .hit (ba == BA_W'(b)), .ap (ap), .bl_one (bl_one),
            .end_hit (burst_end && (end_bank == BA_W'(b))),
            .st (bank_st[b])
         );
         assign bank_open[b] = (bank_st[b] != B_IDLE);
         assign apre_vec[b]  = (bank_st[b] == B_APRE);
      end
   endgenerate

   assign any_open = |bank_open;
   assign sel_st   = bank_st[ba];
   assign rdwr     = (cmd == C_RD) || (cmd == C_WR);

   always_comb begin
      new_err            = '0;
      new_err[E_BUSY]    = (cmd == C_MRS || cmd == C_REF) && any_open;
      new_err[E_GUARD]   = (cmd != C_NOP) && (guard_q != '0);
      new_err[E_IDLE]    = rdwr && (sel_st == B_IDLE);
      new_err[E_ACTOPEN] = (cmd == C_ACT) && (sel_st != B_IDLE);
      new_err[E_APBUSY]  = rdwr && (sel_st == B_APRE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cke_q   <= 1'b0;
         mode_q  <= MODE_RST;
         guard_q <= '0;
         err_q   <= '0;
         cnt_q   <= '0;
      end else begin
         cke_q <= cke;
         if (cmd == C_MRS) begin
            mode_q  <= mode_key;
            guard_q <= GW'(MRS_GAP);
         end else if (guard_q != '0) begin
            guard_q <= guard_q - GW'(1);
         end
         err_q <= (clr ? '0 : err_q) | new_err;
         if (|new_err && (clr || cnt_q != CMAX))
            cnt_q <= (clr ? '0 : cnt_q) + CNT_W'(1);
         else if (clr)
            cnt_q <= '0;
      end
   end

   assign err_vec    = err_q;
   assign err_cnt    = cnt_q;
   assign cas_lat    = mode_q[6:4];
   assign burst_code = mode_q[2:0];
   assign burst_ilv  = mode_q[3];

   a_r4_act_open_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == C_ACT && bank_st[ba] != B_IDLE) |=> err_q[E_ACTOPEN]);

   a_r3_guard_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != C_NOP && guard_q != '0) |=> err_q[E_GUARD]);

   a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((err_q & $past(err_q)) == $past(err_q)));

   a_r12_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CMAX && !clr) |=> (cnt_q == CMAX));

   a_r5_single_apre: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(apre_vec));
endmodule

// File: tb/tb_sdram_cmd_monitor.sv
`timescale 1ns/1ps
module tb_sdram_cmd_monitor;
   logic       clk = 1'b0;
   logic       rst_n, clr, cke, cs_n, ras_n, cas_n, we_n, ap;
   logic [6:0] mode_key;
   logic [1:0] ba;
   logic [7:0] dqm;
   logic [4:0] err_vec;
   logic [7:0] err_cnt;
   logic [3:0] bank_open;
   logic [2:0] cas_lat, burst_code;
   logic       burst_ilv, rd_slot;
   logic [7:0] rd_hiz, wr_mask;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   sdram_cmd_monitor dut (
      .clk (clk), .rst_n (rst_n), .clr (clr), .cke (cke), .cs_n (cs_n),
      .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .ap (ap),
      .mode_key (mode_key), .ba (ba), .dqm (dqm), .err_vec (err_vec),
      .err_cnt (err_cnt), .bank_open (bank_open), .cas_lat (cas_lat),
      .burst_code (burst_code), .burst_ilv (burst_ilv), .rd_slot (rd_slot),
      .rd_hiz (rd_hiz), .wr_mask (wr_mask)
   );

   localparam logic [3:0] K_NOP = 4'b0111, K_ACT = 4'b0011, K_RD = 4'b0101,
                          K_WR = 4'b0100, K_PRE = 4'b0010, K_REF = 4'b0001,
                          K_MRS = 4'b0000, K_BST = 4'b0110, K_DES = 4'b1011;
   localparam logic [6:0] MA = 7'b010_0_010;  // latency 2, sequential, 4 beats
   localparam logic [6:0] MB = 7'b011_1_011;  // latency 3, interleaved, 8 beats
   localparam logic [6:0] MC = 7'b010_0_000;  // latency 2, 1 beat

   // {cmd, ap, ba, mode, expected err_vec, expected bank_open}
   localparam logic [22:0] TBL [15] = '{
      {K_NOP, 1'b0, 2'd0, 7'd0, 5'b00000, 4'b0000},
      {K_MRS, 1'b0, 2'd0, MA,   5'b00000, 4'b0000},
      {K_NOP, 1'b0, 2'd0, 7'd0, 5'b00000, 4'b0000},
      {K_NOP, 1'b0, 2'd0, 7'd0, 5'b00000, 4'b0000},
      {K_ACT, 1'b0, 2'd0, 7'd0, 5'b00000, 4'b0001},
      {K_ACT, 1'b0, 2'd1, 7'd0, 5'b00000, 4'b0011},
      {K_ACT, 1'b0, 2'd0, 7'd0, 5'b01000, 4'b0011},  // R4 activate open bank
      {K_RD,  1'b0, 2'd2, 7'd0, 5'b01100, 4'b0011},  // R4 read idle bank
      {K_PRE, 1'b1, 2'd0, 7'd0, 5'b01100, 4'b0000},  // R13 precharge all
      {K_REF, 1'b0, 2'd0, 7'd0, 5'b01100, 4'b0000},  // R2 legal refresh
      {K_MRS, 1'b0, 2'd0, MA,   5'b01100, 4'b0000},
      {K_ACT, 1'b0, 2'd3, 7'd0, 5'b01110, 4'b1000},  // R3 guard
      {K_NOP, 1'b0, 2'd0, 7'd0, 5'b01110, 4'b1000},
      {K_NOP, 1'b0, 2'd0, 7'd0, 5'b01110, 4'b1000},
      {K_REF, 1'b0, 2'd0, 7'd0, 5'b01111, 4'b1000}   // R2 refresh with open bank
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic st(input logic [3:0] c, input logic a, input logic [1:0] b,
                     input logic [6:0] md, input logic [7:0] dq);
      {cs_n, ras_n, cas_n, we_n} = c;
      ap = a;
      ba = b;
      mode_key = md;
      dqm = dq;
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      rst_n = 1'b0; clr = 1'b0; cke = 1'b1;
      {cs_n, ras_n, cas_n, we_n} = K_NOP;
      ap = 1'b0; ba = '0; mode_key = '0; dqm = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state (R6 defaults, R11, R12)
      chk("R11 reset err", 32'(err_vec), 32'h0);
      chk("R12 reset cnt", 32'(err_cnt), 32'h0);
      chk("R6 reset latency", 32'(cas_lat), 32'd3);
      chk("R6 reset burst", 32'({burst_ilv, burst_code}), 32'h0);
      chk("R13 reset banks", 32'(bank_open), 32'h0);

      for (int i = 0; i < 15; i++) begin
         st(TBL[i][22:19], TBL[i][18], TBL[i][17:16], TBL[i][15:9], 8'h00);
         chk($sformatf("R2/R3/R4/R11 vector %0d err", i), 32'(err_vec), 32'(TBL[i][8:4]));
         chk($sformatf("R1/R13 vector %0d banks", i), 32'(bank_open), 32'(TBL[i][3:0]));
      end
      chk("R12 violation count", 32'(err_cnt), 32'd4);
      chk("R6 latency field", 32'(cas_lat), 32'd2);
      chk("R6 burst fields", 32'({burst_ilv, burst_code}), 32'h2);

      // R11 clear
      clr = 1'b1; st(K_NOP, 0, 0, 0, 0); clr = 1'b0;
      chk("R11 clear err", 32'(err_vec), 32'h0);
      chk("R12 clear cnt", 32'(err_cnt), 32'h0);

      // R1 gating by previous cke and by chip select
      cke = 1'b0; st(K_NOP, 0, 0, 0, 0);
      cke = 1'b1; st(K_ACT, 0, 0, 0, 0);
      chk("R1 cke low before", 32'(bank_open), 32'h8);
      st(K_DES, 0, 0, 0, 0);
      chk("R1 deselect", 32'(bank_open), 32'h8);
      st(K_ACT, 0, 0, 0, 0);
      chk("R1 decoded activate", 32'(bank_open), 32'h9);

      // R13 single and all-bank precharge
      st(K_PRE, 0, 3, 0, 0);
      chk("R13 single precharge", 32'(bank_open), 32'h1);
      st(K_PRE, 1, 2, 0, 0);
      chk("R13 all precharge", 32'(bank_open), 32'h0);
      chk("R13 no error", 32'(err_vec), 32'h0);

      // R5 auto-precharge busy, interrupted
      st(K_ACT, 0, 0, 0, 0);
      st(K_RD, 1, 0, 0, 0);
      st(K_NOP, 0, 0, 0, 0);
      chk("R5 busy bank open", 32'(bank_open), 32'h1);
      st(K_RD, 0, 0, 0, 0);
      chk("R5 busy flag", 32'(err_vec), 32'h10);
      chk("R5 interrupted burst closes", 32'(bank_open), 32'h0);
      // R5 natural end on last beat
      st(K_ACT, 0, 0, 0, 0);
      st(K_WR, 1, 0, 0, 0);
      st(K_NOP, 0, 0, 0, 0);
      st(K_NOP, 0, 0, 0, 0);
      chk("R5 busy before last beat", 32'(bank_open), 32'h1);
      st(K_NOP, 0, 0, 0, 0);
      chk("R5 idle after last beat", 32'(bank_open), 32'h0);
      clr = 1'b1; st(K_NOP, 0, 0, 0, 0); clr = 1'b0;

      // R7 / R9 read slots and read masking (latency 2, 4 beats)
      st(K_ACT, 0, 1, 0, 0);
      st(K_RD, 0, 1, 0, 0);
      chk("R7 no slot before latency", 32'(rd_slot), 32'h0);
      st(K_NOP, 0, 0, 0, 8'h00);
      chk("R7 first slot", 32'(rd_slot), 32'h1);
      st(K_NOP, 0, 0, 0, 8'hFF);
      chk("R9 mask not yet", 32'(rd_hiz), 32'h0);
      st(K_NOP, 0, 0, 0, 8'h00);
      chk("R9 masked beat", 32'(rd_hiz), 32'hFF);
      st(K_NOP, 0, 0, 0, 8'h00);
      chk("R7 last slot", 32'(rd_slot), 32'h1);
      chk("R9 mask gone", 32'(rd_hiz), 32'h0);
      st(K_NOP, 0, 0, 0, 8'h00);
      chk("R7 slots end", 32'(rd_slot), 32'h0);

      // R8 burst stop
      st(K_RD, 0, 1, 0, 0);
      st(K_BST, 0, 0, 0, 0);
      chk("R8 beat before stop", 32'(rd_slot), 32'h1);
      st(K_NOP, 0, 0, 0, 0);
      chk("R8 stopped", 32'(rd_slot), 32'h0);

      // R10 write masking
      st(K_WR, 0, 1, 0, 8'h00);
      st(K_NOP, 0, 0, 0, 8'h0F);
      chk("R10 write beat mask", 32'(wr_mask), 32'h0F);
      st(K_NOP, 0, 0, 0, 8'h00);
      st(K_NOP, 0, 0, 0, 8'h00);
      st(K_NOP, 0, 0, 0, 8'h0F);
      chk("R10 no mask outside burst", 32'(wr_mask), 32'h0);
      chk("R10 no error", 32'(err_vec), 32'h0);

      // R6 / R7 latency 3, interleaved, 8 beats
      st(K_PRE, 1, 0, 0, 0);
      st(K_MRS, 0, 0, MB, 0);
      st(K_NOP, 0, 0, 0, 0);
      st(K_NOP, 0, 0, 0, 0);
      chk("R6 latency 3", 32'(cas_lat), 32'd3);
      chk("R6 interleave 8", 32'({burst_ilv, burst_code}), 32'hB);
      st(K_ACT, 0, 2, 0, 0);
      st(K_RD, 0, 2, 0, 0);
      for (int k = 1; k <= 10; k++) begin
         st(K_NOP, 0, 0, 0, 0);
         if (k == 1)  chk("R7 CL3 not yet", 32'(rd_slot), 32'h0);
         if (k == 2)  chk("R7 CL3 first", 32'(rd_slot), 32'h1);
         if (k == 9)  chk("R7 BL8 last", 32'(rd_slot), 32'h1);
         if (k == 10) chk("R7 BL8 end", 32'(rd_slot), 32'h0);
      end
      chk("R2 legal mode load", 32'(err_vec), 32'h0);

      // R12 saturation
      for (int k = 0; k < 260; k++) st(K_ACT, 0, 2, 0, 0);
      chk("R12 saturated", 32'(err_cnt), 32'd255);
      chk("R4 repeated activate", 32'(err_vec), 32'h08);
      clr = 1'b1; st(K_NOP, 0, 0, 0, 0); clr = 1'b0;

      // R5 with 1-beat bursts
      st(K_PRE, 1, 0, 0, 0);
      st(K_MRS, 0, 0, MC, 0);
      st(K_NOP, 0, 0, 0, 0);
      st(K_NOP, 0, 0, 0, 0);
      st(K_ACT, 0, 0, 0, 0);
      chk("R5 open before", 32'(bank_open), 32'h1);
      st(K_RD, 1, 0, 0, 0);
      chk("R5 BL1 closes at once", 32'(bank_open), 32'h0);
      chk("R5 BL1 no error", 32'(err_vec), 32'h0);

      done = 1'b1;
      finish_run();
   end
endmodule